// File: doc/BRIEF.md
# Periodic Down-Counting Slice Timer

A single periodic timer built on a 32-bit down counter that advances on every clock, with no prescaler. Software programs a terminal count, then sets the enable bit. The counter loads the terminal count on the next clock and decrements from there. When it reaches zero, a sticky expiry flag is raised. If the interrupt enable is set, that flag drives the block's own interrupt line.

After an expiry the timer behaves in one of two ways. In auto-reload mode it reloads the terminal count and keeps running. In one-shot-wait mode it parks at zero until software acknowledges the flag by writing 1 to it. Turning the enable off freezes the counter and drops both the flag and the interrupt. The live count can be read at any moment and the read does not disturb counting. Terminal counts of 255 or less are outside the supported range. A second timer is simply a second instance.

Top module: `slice_timer`

## Requirements
- R1: After reset, the terminal count, control, count and status registers all read 0, and irq_o is 0.
- R2: The four word registers sit at byte offsets 0x0 (terminal count, read/write), 0x4 (control: bit 24 enable, bit 25 interrupt enable, bit 26 auto-reload when 1), 0x8 (current count, read-only: writes are ignored) and 0xC (status: expiry flag at bit 24). Control bits other than 24..26 read as 0.
- R3: On the clock after the enable goes from 0 to 1, the count equals the terminal count. It then decreases by exactly one per clock, and reading it does not alter it.
- R4: On the first clock at which a running count is 0, the expiry flag is set. In auto-reload mode the count is reloaded with the terminal count on that same clock, so the period is terminal count + 1 clocks.
- R5: In wait mode the count holds at 0 after an expiry until the flag is cleared, and is reloaded with the terminal count on the clock after the clear.
- R6: Writing 1 to status bit 24 clears the flag and writing 0 has no effect. If a clearing write and a new expiry fall on the same clock, the flag stays set.
- R7: irq_o is 1 exactly when the expiry flag and the interrupt enable are both 1.
- R8: A control write with enable 0 clears the flag and irq_o on that write's clock, and the count stays frozen at its value while disabled.
- R9: A terminal count written while the timer runs does not change the current count, and is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset of the word register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Expiry interrupt |

## Verification
The hardest case to reach is a write-1 acknowledge that lands on the very clock of the next auto-reload expiry. Only there does the set-over-clear priority show. The stimulus reaches that clock by counting exact clock edges from the enable write, using the known period of terminal count + 1. It then times the status write so that its clock edge coincides with the expiry. A second acknowledge, three clocks later, shows that the flag really was re-set and not merely left over.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int unsigned OFS_TC     = 0;
  localparam int unsigned OFS_CTRL   = 4;
  localparam int unsigned OFS_CNT    = 8;
  localparam int unsigned OFS_STAT   = 12;
  localparam int unsigned BIT_EN     = 24;
  localparam int unsigned BIT_IE     = 25;
  localparam int unsigned BIT_RELOAD = 26;
  localparam int unsigned BIT_EXP    = 24;

  typedef struct packed {
    logic reload;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/slt_count.sv
module slt_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] tc_i,
  input  logic             status_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             en_prev_q;
  logic             wait_q;

  assign expire_o = run_i && en_prev_q && !wait_q && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      en_prev_q <= 1'b0;
      wait_q    <= 1'b0;
    end else begin
      en_prev_q <= run_i;
      if (!run_i) begin
        wait_q <= 1'b0;                     // frozen count
      end else if (!en_prev_q) begin
        cnt_q  <= tc_i;                     // enable edge
        wait_q <= 1'b0;
      end else if (wait_q) begin
        if (!status_i) begin
          cnt_q  <= tc_i;
          wait_q <= 1'b0;
        end
      end else if (cnt_q == '0) begin
        if (reload_i) cnt_q <= tc_i;
        else          wait_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !en_prev_q) |=> (cnt_q == $past(tc_i)));
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && en_prev_q && !wait_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && reload_i) |=> (cnt_q == $past(tc_i)));
  a_r5_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wait_q && status_i) |=> (cnt_q == '0));
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/slt_regs.sv
module slt_regs import slt_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic [CNT_W-1:0]  tc_o,
  output ctrl_t             ctrl_o,
  output logic              status_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_TC   = ADDR_W'(OFS_TC);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic [CNT_W-1:0] tc_q;
  ctrl_t            ctrl_q, ctrl_d;
  logic             status_q;
  logic             wr_tc, wr_ctrl, wr_stat;

  assign wr_tc   = req_i && we_i && (addr_i == A_TC);
  assign wr_ctrl = req_i && we_i && (addr_i == A_CTRL);
  assign wr_stat = req_i && we_i && (addr_i == A_STAT);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en     = wdata_i[BIT_EN];
      ctrl_d.ie     = wdata_i[BIT_IE];
      ctrl_d.reload = wdata_i[BIT_RELOAD];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q     <= '0;
      ctrl_q   <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_tc) tc_q <= wdata_i[CNT_W-1:0];
      ctrl_q <= ctrl_d;
      // disable beats expiry, expiry beats acknowledge
      if (!ctrl_d.en)                      status_q <= 1'b0;
      else if (expire_i)                   status_q <= 1'b1;
      else if (wr_stat && wdata_i[BIT_EXP]) status_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_TC:   rdata_o = DATA_W'(tc_q);
      A_CTRL: begin
        rdata_o[BIT_EN]     = ctrl_q.en;
        rdata_o[BIT_IE]     = ctrl_q.ie;
        rdata_o[BIT_RELOAD] = ctrl_q.reload;
      end
      A_CNT:  rdata_o = DATA_W'(cnt_i);
      A_STAT: rdata_o[BIT_EXP] = status_q;
      default: rdata_o = '0;
    endcase
  end

  assign tc_o     = tc_q;
  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;
  assign irq_o    = status_q && ctrl_q.ie;

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_d.en && expire_i) |=> status_q);
  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[BIT_EXP] && !expire_i) |=> !status_q);
  a_r8_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !wdata_i[BIT_EN]) |=> (!status_q && !irq_o));
  a_r9_tc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_tc |=> $stable(tc_q));
endmodule

// File: rtl/slice_timer.sv
module slice_timer import slt_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] tc, cnt;
  ctrl_t            ctrl;
  logic             status, expire;

  slt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt),
    .expire_i (expire),
    .tc_o     (tc),
    .ctrl_o   (ctrl),
    .status_o (status),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o)
  );

  slt_count #(.CNT_W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl.en),
    .reload_i (ctrl.reload),
    .tc_i     (tc),
    .status_i (status),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  a_r7_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl.en && status));
endmodule

// File: tb/slice_timer_test.sv
`timescale 1ns/100ps
module slice_timer_test;
  localparam logic [3:0]  A_TC = 4'h0, A_CTRL = 4'h4, A_CNT = 4'h8, A_STAT = 4'hC;
  localparam logic [31:0] EN = 32'h0100_0000, IE = 32'h0200_0000, RL = 32'h0400_0000;
  localparam logic [31:0] ST = 32'h0100_0000;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, probe = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  item_t       sb[$];
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  slice_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // monitor: compare on the falling edge
  always @(negedge clk) begin
    if ((req_i && !we_i) || probe) begin
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: act %h exp none", rdata_o);
      end else begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : rdata_o;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: act %h exp %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    sb.push_back('{e, 1'b0, t});
    @(negedge clk); #1;
    req_i = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(posedge clk); #1;
    probe = 1'b1;
    sb.push_back('{{31'b0, e}, 1'b1, t});
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act running exp finished");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    rd(A_TC, 0, "R1 tc");
    rd(A_CTRL, 0, "R1 ctrl");
    rd(A_CNT, 0, "R1 cnt");
    rd(A_STAT, 0, "R1 stat");
    chk_irq(1'b0, "R1 irq");

    // run A: auto-reload with interrupt, tc=300, enable edge E0
    wr(A_TC, 300);
    rd(A_TC, 300, "R2 tc readback");
    wr(A_CTRL, EN | IE | RL);
    rd(A_CNT, 300, "R3 load E1");
    rd(A_CNT, 299, "R3 step E2");
    idle(10);
    rd(A_CNT, 288, "R3 reads do not disturb E13");
    idle(287);
    rd(A_CNT, 0, "R4 zero E301");
    rd(A_STAT, ST, "R4 flag E302");
    rd(A_CNT, 299, "R4 reloaded E303");
    chk_irq(1'b1, "R7 irq E304");
    wr(A_STAT, ST);
    rd(A_STAT, 0, "R6 w1c E307");
    chk_irq(1'b0, "R7 irq after clear");
    idle(295);
    rd(A_STAT, ST, "R4 period tc+1 E604");
    chk_irq(1'b1, "R7 irq second expiry");
    wr(A_CTRL, 0);
    rd(A_STAT, 0, "R8 disable clears flag");
    chk_irq(1'b0, "R8 disable clears irq");
    rd(A_CTRL, 0, "R2 ctrl off");
    rd(A_CNT, 296, "R8 frozen count");
    wr(A_CNT, 32'h5);
    rd(A_CNT, 296, "R2 count read-only");
    wr(A_CTRL, 32'h00FF_00FF);
    rd(A_CTRL, 0, "R2 reserved ctrl bits zero");

    // run B: auto-reload, no interrupt, tc changed while running
    wr(A_CTRL, EN | RL);
    rd(A_CNT, 300, "R3 reload on re-enable");
    wr(A_TC, 260);
    rd(A_CNT, 297, "R9 running count unaffected");
    idle(297);
    rd(A_CNT, 260, "R9 new tc at reload");
    rd(A_STAT, ST, "R4 flag run B");
    chk_irq(1'b0, "R7 irq masked");
    idle(257);
    wr(A_STAT, ST);                       // lands on expiry clock E563
    rd(A_STAT, ST, "R6 expiry beats clear");
    wr(A_STAT, ST);
    rd(A_STAT, 0, "R6 later clear");
    wr(A_CTRL, 0);

    // run C: wait mode with interrupt, tc=256
    wr(A_TC, 256);
    wr(A_CTRL, EN | IE);
    rd(A_CNT, 256, "R3 load wait mode");
    idle(300);
    rd(A_CNT, 0, "R5 parked at zero");
    rd(A_STAT, ST, "R5 flag set");
    chk_irq(1'b1, "R7 irq wait mode");
    wr(A_STAT, 0);
    rd(A_STAT, ST, "R6 write 0 no effect");
    rd(A_CNT, 0, "R5 still parked");
    wr(A_STAT, ST);
    rd(A_CNT, 256, "R5 reload after clear");
    rd(A_CNT, 255, "R5 counting again");
    chk_irq(1'b0, "R7 irq cleared");
    rd(A_STAT, 0, "R6 flag cleared");

    idle(2);
    report();
  end
endmodule